// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger

This block sits beside a processor's debug comparators and decides when a breakpoint response is raised. The comparators for the program counter, bus address and bus data are not part of the block: each cycle they deliver match flags, and the block combines those flags under a 32-bit trigger definition word. Software loads that word through a simple write-only port. The word describes two trigger levels, a first level and a second level, plus the response to raise once the trigger completes.

Each level combines its enabled conditions in one of two ways. It can require the PC, address and data conditions all together, or it can accept either the PC condition alone or the address and data conditions together. The first level is evaluated first. When the second level is enabled, a first-level hit arms it, and only a later second-level hit completes the trigger. When only the first level is enabled, a first-level hit completes the trigger directly. A completed trigger always produces a trace pulse. Depending on the response code it can also produce a one-cycle halt request or a one-cycle debug-interrupt request. A two-bit status output shows the progress of the sequence and holds its final value until the next register write.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the status output is 00 (idle), every pulse output is low, and the definition word is zero, so no match input has any effect until a write occurs.
- R2: A write loads the whole definition word and restarts the status: it becomes 01 (first level armed) when bit 13 (first-level enable) of the written word is 1, and 00 (idle) otherwise. This applies from any status, including 11.
- R3: When a write and a completing match arrive in the same cycle, the write wins. No pulse output rises and the status follows R2.
- R4: A level whose combine bit is 0 fires when its PC term, its address term and its data term are all true. The combine bit is bit 14 for the first level and bit 15 for the second level.
- R5: A level whose combine bit is 1 fires when its PC term is true, or when its address term and its data term are both true.
- R6: Each level has a 13-bit condition field: bits 12:0 for the first level and bits 28:16 for the second. Inside that field, [6:0] are data-lane enables, [7] inverts the data result, [10:8] are address-flag enables, [11] is the PC enable and [12] inverts the PC flag. The address term is the OR of the enabled address flags, and is true when no address enables are set. The data term is the OR of the enabled data flags XOR the data invert bit, and is true when no data enables are set. A disabled PC term counts as true when the combine bit is 0 and as false when it is 1.
- R7: With both levels enabled (bits 13 and 29), a first-level hit while the status is 01 moves the status to 10 and pulses trace_stage1 in the next cycle. The second level is evaluated only while the status is 10, so a second-level match in the same cycle as the first-level hit does not complete the trigger.
- R8: With only the first level enabled, a first-level hit while the status is 01 completes the trigger and the status becomes 11.
- R9: Bits 31:30 select the response. 00 produces the trace pulse only, 01 adds halt_req, 10 adds dbg_irq, and 11 behaves as 00. trace_hit pulses on every completion.
- R10: The response pulses last exactly one cycle and appear in the cycle after the completing match. Status 11 holds, and later matches produce no pulses, until the next write.
- R11: When bit 13 is 0 the status stays 00 and no pulse rises, whatever the match inputs or the second-level enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the definition word |
| cfg_wdata | input | 32 | Definition word written when cfg_we is high |
| pc_match | input | 1 | PC comparator match flag |
| addr_match | input | NADDR (3) | Address comparator match flags |
| data_match | input | NDATA (7) | Data comparator match flags, one per lane |
| trig_state | output | 2 | Status: 00 idle, 01 first level armed, 10 second level armed, 11 complete |
| trace_hit | output | 1 | One-cycle pulse when the trigger completes |
| trace_stage1 | output | 1 | One-cycle pulse when a first-level hit arms the second level |
| halt_req | output | 1 | One-cycle halt request (response 01) |
| dbg_irq | output | 1 | One-cycle debug-interrupt request (response 10) |

## Verification
Two functions can land in the same cycle. A register write restarts the status, and a match completes or advances the sequence. The bench provokes this by presenting a completing PC match in the same cycle as a write, first re-writing the same word and then writing a word with the first level disabled. It judges the result by the status and pulse outputs one cycle later: there must be no pulse, and the status must follow the written enable. A second case places first-level and second-level matches in the same cycle, and the bench checks that only the arming step (status 10 with a stage pulse) results.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned HALF_W = REG_W / 2;
   localparam int unsigned COND_W = HALF_W - 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ARM1 = 2'b01,
      ST_ARM2 = 2'b10,
      ST_DONE = 2'b11
   } trig_st_e;

   typedef enum logic [1:0] {
      RSP_SHOW = 2'b00,
      RSP_HALT = 2'b01,
      RSP_IRQ  = 2'b10,
      RSP_RSVD = 2'b11
   } trig_rsp_e;

   typedef struct packed {
      logic              en;
      logic              any_or;
      logic [COND_W-1:0] cond;
   } lvl_cfg_t;
endpackage

// File: rtl/dbg_trig_defreg.sv
module dbg_trig_defreg
   import dbg_trig_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output lvl_cfg_t         lvl1_cfg,
   output lvl_cfg_t         lvl2_cfg,
   output trig_rsp_e        rsp
);
   localparam int unsigned L1_EN  = HALF_W - 3;
   localparam int unsigned L1_OR  = HALF_W - 2;
   localparam int unsigned L2_OR  = HALF_W - 1;
   localparam int unsigned L2_EN  = REG_W - 3;
   localparam int unsigned RSP_LO = REG_W - 2;

   if (REG_W % 2 != 0 || COND_W < 1) begin : g_bad_width
      $error("definition word width must be even and leave room for conditions");
   end

   logic [REG_W-1:0] def_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     def_q <= '0;
      else if (wr_en) def_q <= wr_data;
   end

   assign lvl1_cfg.en     = def_q[L1_EN];
   assign lvl1_cfg.any_or = def_q[L1_OR];
   assign lvl1_cfg.cond   = def_q[COND_W-1:0];
   assign lvl2_cfg.en     = def_q[L2_EN];
   assign lvl2_cfg.any_or = def_q[L2_OR];
   assign lvl2_cfg.cond   = def_q[HALF_W+COND_W-1:HALF_W];
   assign rsp             = trig_rsp_e'(def_q[REG_W-1:RSP_LO]);

   // a write lands in the level fields one cycle later (R2)
   p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (lvl1_cfg.en == $past(wr_data[L1_EN])) &&
                (lvl2_cfg.en == $past(wr_data[L2_EN])));

   // without a write the response code does not move (R9)
   p_rsp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rsp));
endmodule

// File: rtl/dbg_trig_level.sv
module dbg_trig_level
   import dbg_trig_pkg::*;
#(
   parameter int unsigned NDATA    = 7,
   parameter int unsigned NADDR    = 3,
   parameter bit          ALLOW_OR = 1'b1
) (
   input  lvl_cfg_t         cfg,
   input  logic             pc_hit,
   input  logic [NADDR-1:0] addr_hit,
   input  logic [NDATA-1:0] data_hit,
   output logic             fire
);
   localparam int unsigned D_INV  = NDATA;
   localparam int unsigned A_LO   = NDATA + 1;
   localparam int unsigned A_HI   = A_LO + NADDR - 1;
   localparam int unsigned PC_EN  = A_HI + 1;
   localparam int unsigned PC_INV = PC_EN + 1;

   if (PC_INV != COND_W - 1 || NDATA < 1 || NADDR < 1) begin : g_bad_split
      $error("data, address and PC fields must fill the condition field exactly");
   end

   logic [NDATA-1:0] data_en;
   logic [NADDR-1:0] addr_en;
   logic             data_ok;
   logic             addr_ok;
   logic             pc_on;
   logic             pc_val;

   assign data_en = cfg.cond[NDATA-1:0];
   assign addr_en = cfg.cond[A_HI:A_LO];
   assign pc_on   = cfg.cond[PC_EN];
   assign pc_val  = pc_hit ^ cfg.cond[PC_INV];

   // an empty enable set makes the term true (R6)
   assign data_ok = (data_en == '0) ? 1'b1 : ((|(data_en & data_hit)) ^ cfg.cond[D_INV]);
   assign addr_ok = (addr_en == '0) ? 1'b1 : (|(addr_en & addr_hit));

   if (ALLOW_OR) begin : g_both_modes
      always_comb begin
         if (cfg.any_or) fire = cfg.en & ((pc_on & pc_val) | (addr_ok & data_ok));
         else            fire = cfg.en & (pc_on ? pc_val : 1'b1) & addr_ok & data_ok;
      end
   end else begin : g_and_only
      logic unused_or;
      assign unused_or = cfg.any_or;
      assign fire = cfg.en & (pc_on ? pc_val : 1'b1) & addr_ok & data_ok;
   end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
   import dbg_trig_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      wr_l1_en,
   input  logic      l2_en,
   input  trig_rsp_e rsp,
   input  logic      l1_fire,
   input  logic      l2_fire,
   output trig_st_e  state,
   output logic      trace_hit,
   output logic      trace_stage1,
   output logic      halt_req,
   output logic      dbg_irq
);
   trig_st_e st_n;
   logic     done_n;
   logic     stage_n;

   always_comb begin
      st_n    = state;
      done_n  = 1'b0;
      stage_n = 1'b0;
      if (wr_en) begin
         st_n = wr_l1_en ? ST_ARM1 : ST_IDLE;
      end else begin
         unique case (state)
            ST_ARM1: if (l1_fire) begin
               if (l2_en) begin
                  st_n    = ST_ARM2;
                  stage_n = 1'b1;
               end else begin
                  st_n   = ST_DONE;
                  done_n = 1'b1;
               end
            end
            ST_ARM2: if (l2_fire) begin
               st_n   = ST_DONE;
               done_n = 1'b1;
            end
            default: st_n = state;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         trace_hit    <= 1'b0;
         trace_stage1 <= 1'b0;
         halt_req     <= 1'b0;
         dbg_irq      <= 1'b0;
      end else begin
         state        <= st_n;
         trace_hit    <= done_n;
         trace_stage1 <= stage_n;
         halt_req     <= done_n && (rsp == RSP_HALT);
         dbg_irq      <= done_n && (rsp == RSP_IRQ);
      end
   end

   p_halt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> !halt_req);
   p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_irq |=> !dbg_irq);
   p_rsp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_req && dbg_irq));
   p_rsp_traced_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req || dbg_irq) |-> trace_hit);
   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && !wr_en) |=> (state == ST_DONE && !trace_hit));
   p_idle_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !wr_en) |=> (state == ST_IDLE && !trace_hit));
   p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!trace_hit && !trace_stage1 && state != ST_DONE));
   p_stage_enters_arm2_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trace_stage1 |-> (state == ST_ARM2 && $past(state) == ST_ARM1));
   p_hit_means_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trace_hit |-> state == ST_DONE);
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dbg_trig_pkg::*;
#(
   parameter int unsigned NDATA    = 7,
   parameter int unsigned NADDR    = 3,
   parameter bit          ALLOW_OR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             pc_match,
   input  logic [NADDR-1:0] addr_match,
   input  logic [NDATA-1:0] data_match,
   output logic [1:0]       trig_state,
   output logic             trace_hit,
   output logic             trace_stage1,
   output logic             halt_req,
   output logic             dbg_irq
);
   localparam int unsigned NLVL  = 2;
   localparam int unsigned L1_EN = HALF_W - 3;

   lvl_cfg_t  lvl_cfg [NLVL];
   logic      [NLVL-1:0] lvl_fire;
   trig_rsp_e rsp;
   trig_st_e  state;

   dbg_trig_defreg i_defreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_data  (cfg_wdata),
      .lvl1_cfg (lvl_cfg[0]),
      .lvl2_cfg (lvl_cfg[1]),
      .rsp      (rsp)
   );

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      dbg_trig_level #(
         .NDATA    (NDATA),
         .NADDR    (NADDR),
         .ALLOW_OR (ALLOW_OR)
      ) i_level (
         .cfg      (lvl_cfg[g]),
         .pc_hit   (pc_match),
         .addr_hit (addr_match),
         .data_hit (data_match),
         .fire     (lvl_fire[g])
      );
   end

   dbg_trig_seq i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (cfg_we),
      .wr_l1_en     (cfg_wdata[L1_EN]),
      .l2_en        (lvl_cfg[1].en),
      .rsp          (rsp),
      .l1_fire      (lvl_fire[0]),
      .l2_fire      (lvl_fire[1]),
      .state        (state),
      .trace_hit    (trace_hit),
      .trace_stage1 (trace_stage1),
      .halt_req     (halt_req),
      .dbg_irq      (dbg_irq)
   );

   assign trig_state = state;

   // the second level can only complete after the first has armed it (R7)
   p_arm2_before_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && $past(state) == ST_ARM2) |-> $past(lvl_fire[1]));
endmodule

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        pc_match = 1'b0;
   logic [2:0]  addr_match = '0;
   logic [6:0]  data_match = '0;
   logic [1:0]  trig_state;
   logic        trace_hit, trace_stage1, halt_req, dbg_irq;

   always #10 clk = ~clk;

   dbg_trig_unit i_dbg_trig_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .pc_match(pc_match), .addr_match(addr_match), .data_match(data_match),
      .trig_state(trig_state), .trace_hit(trace_hit), .trace_stage1(trace_stage1),
      .halt_req(halt_req), .dbg_irq(dbg_irq)
   );

   typedef struct {
      logic [1:0] st;
      logic       th, ts, hr, di;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;

   logic [31:0] m_reg = '0;
   logic [1:0]  m_st  = 2'b00;

   localparam logic [12:0] C_PC   = 13'h0800;
   localparam logic [12:0] C_PINV = 13'h1000;
   localparam logic [12:0] C_A0   = 13'h0100;
   localparam logic [12:0] C_A1   = 13'h0200;
   localparam logic [12:0] C_D0   = 13'h0001;
   localparam logic [12:0] C_DINV = 13'h0080;

   function automatic logic [31:0] word(input logic [1:0] rsp, input logic l2en,
      input logic [12:0] c2, input logic l2or, input logic l1or, input logic l1en,
      input logic [12:0] c1);
      return {rsp, l2en, c2, l2or, l1or, l1en, c1};
   endfunction

   // level evaluation from the R4/R5/R6 field rules
   function automatic logic lvl_hit(input logic [31:0] r, input bit second,
      input logic pc, input logic [2:0] a, input logic [6:0] d);
      logic [12:0] c;
      logic en, orm, aok, dok, pct;
      c   = second ? r[28:16] : r[12:0];
      en  = second ? r[29] : r[13];
      orm = second ? r[15] : r[14];
      aok = (c[10:8] == 3'b0) ? 1'b1 : |(c[10:8] & a);
      dok = (c[6:0] == 7'b0) ? 1'b1 : ((|(c[6:0] & d)) ^ c[7]);
      if (orm) begin
         pct = c[11] & (pc ^ c[12]);
         return en & (pct | (aok & dok));
      end
      pct = c[11] ? (pc ^ c[12]) : 1'b1;
      return en & pct & aok & dok;
   endfunction

   task automatic step(input logic we, input logic [31:0] wd, input logic pc,
      input logic [2:0] a, input logic [6:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      cfg_we = we; cfg_wdata = wd; pc_match = pc; addr_match = a; data_match = d;
      e.th = 1'b0; e.ts = 1'b0; e.hr = 1'b0; e.di = 1'b0; e.tag = tag;
      if (we) begin
         m_st  = wd[13] ? 2'b01 : 2'b00;
         m_reg = wd;
      end else if (m_st == 2'b01 && lvl_hit(m_reg, 1'b0, pc, a, d)) begin
         if (m_reg[29]) begin
            m_st = 2'b10; e.ts = 1'b1;
         end else begin
            m_st = 2'b11; e.th = 1'b1;
         end
      end else if (m_st == 2'b10 && lvl_hit(m_reg, 1'b1, pc, a, d)) begin
         m_st = 2'b11; e.th = 1'b1;
      end
      if (e.th) begin
         e.hr = (m_reg[31:30] == 2'b01);
         e.di = (m_reg[31:30] == 2'b10);
      end
      e.st = m_st;
      sb_q.push_back(e);
   endtask

   task automatic wr(input logic [31:0] wd, input string tag);
      step(1'b1, wd, 1'b0, 3'b0, 7'b0, tag);
   endtask

   task automatic idle(input logic pc, input logic [2:0] a, input logic [6:0] d,
      input string tag);
      step(1'b0, 32'h0, pc, a, d, tag);
   endtask

   // monitor: pops one expected item per clock after the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (trig_state !== e.st || trace_hit !== e.th || trace_stage1 !== e.ts ||
                halt_req !== e.hr || dbg_irq !== e.di) begin
               n_err++;
               $display("FAIL %s: got st=%b hit=%b stg=%b halt=%b irq=%b exp st=%b hit=%b stg=%b halt=%b irq=%b",
                  e.tag, trig_state, trace_hit, trace_stage1, halt_req, dbg_irq,
                  e.st, e.th, e.ts, e.hr, e.di);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: got no finish exp finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      n_chk++;
      if (trig_state !== 2'b00 || trace_hit || trace_stage1 || halt_req || dbg_irq) begin
         n_err++;
         $display("FAIL R1: got st=%b pulses=%b%b%b%b exp st=00 pulses=0000",
            trig_state, trace_hit, trace_stage1, halt_req, dbg_irq);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R11: no definition yet, matches do nothing
      idle(1'b1, 3'b111, 7'h7f, "R1");
      idle(1'b1, 3'b111, 7'h7f, "R11");
      wr(word(2'b01, 1'b1, C_PC, 1'b0, 1'b0, 1'b0, C_PC), "R11");
      idle(1'b1, 3'b111, 7'h7f, "R11");
      idle(1'b1, 3'b000, 7'h00, "R11");

      // R8 single level with halt response, R10 sticky done
      wr(word(2'b01, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_PC), "R2");
      idle(1'b0, 3'b111, 7'h7f, "R4");
      idle(1'b1, 3'b000, 7'h00, "R8");
      idle(1'b1, 3'b000, 7'h00, "R10");
      idle(1'b1, 3'b111, 7'h7f, "R10");

      // R2 restart from done, R4 AND combining, R9 display-only response
      wr(word(2'b00, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_PC | C_A0 | C_D0), "R2");
      idle(1'b1, 3'b001, 7'h00, "R4");
      idle(1'b1, 3'b000, 7'h01, "R4");
      idle(1'b0, 3'b001, 7'h01, "R4");
      idle(1'b1, 3'b001, 7'h01, "R9");
      idle(1'b0, 3'b000, 7'h00, "R10");

      // R5 OR combining with interrupt response
      wr(word(2'b10, 1'b0, 13'h0, 1'b0, 1'b1, 1'b1, C_PC | C_A0 | C_D0), "R2");
      idle(1'b0, 3'b001, 7'h00, "R5");
      idle(1'b0, 3'b001, 7'h01, "R5");
      wr(word(2'b10, 1'b0, 13'h0, 1'b0, 1'b1, 1'b1, C_PC | C_A0 | C_D0), "R2");
      idle(1'b1, 3'b000, 7'h00, "R5");

      // R6 optional data, optional address, inversions, disabled PC in OR mode
      wr(word(2'b00, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_A0), "R6");
      idle(1'b1, 3'b000, 7'h7f, "R6");
      idle(1'b0, 3'b001, 7'h00, "R6");
      wr(word(2'b00, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_D0 | C_DINV), "R6");
      idle(1'b0, 3'b000, 7'h01, "R6");
      idle(1'b0, 3'b000, 7'h00, "R6");
      wr(word(2'b00, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_PC | C_PINV), "R6");
      idle(1'b1, 3'b000, 7'h00, "R6");
      idle(1'b0, 3'b000, 7'h00, "R6");
      wr(word(2'b00, 1'b0, 13'h0, 1'b0, 1'b1, 1'b1, C_A0), "R6");
      idle(1'b1, 3'b000, 7'h00, "R6");
      idle(1'b0, 3'b001, 7'h00, "R6");

      // R7 two-level sequence, both levels matching in the arming cycle
      wr(word(2'b10, 1'b1, C_A1, 1'b0, 1'b0, 1'b1, C_PC), "R2");
      idle(1'b1, 3'b010, 7'h00, "R7");
      idle(1'b1, 3'b000, 7'h00, "R7");
      idle(1'b0, 3'b010, 7'h00, "R7");
      idle(1'b0, 3'b010, 7'h00, "R10");

      // R9 reserved response acts as display-only
      wr(word(2'b11, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_PC), "R2");
      idle(1'b1, 3'b000, 7'h00, "R9");

      // R3 write collides with a completing match
      wr(word(2'b01, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_PC), "R2");
      step(1'b1, word(2'b01, 1'b0, 13'h0, 1'b0, 1'b0, 1'b1, C_PC), 1'b1, 3'b0, 7'h0, "R3");
      step(1'b1, word(2'b01, 1'b0, 13'h0, 1'b0, 1'b0, 1'b0, C_PC), 1'b1, 3'b0, 7'h0, "R3");
      idle(1'b1, 3'b000, 7'h00, "R3");
      idle(1'b0, 3'b000, 7'h00, "R3");

      @(negedge clk);
      cfg_we = 1'b0; pc_match = 1'b0; addr_match = '0; data_match = '0;
      @(posedge clk);
      #5;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule